// File: doc/BRIEF.md
# GPIO Edge Interrupt Flag Controller

This block watches three general-purpose input ports (A: 8 pins, B: 8 pins, C: 5 pins), brings every pin through a two-stage synchroniser, and detects edges on it. A detected edge of the selected polarity latches a sticky status flag for that pin. The flag is set whether or not any enable is on. Software reads the flags over a small register bus and acknowledges them by writing 0 to the bits it wants cleared.

Each port raises its own interrupt request from its flags. The enables are coarser on some ports than on others. Every pin of port B has its own enable bit. Port A has one enable for pins 3..0 and another for pins 7..4. All of port C shares a single enable. A port-level enable gates each request on top of these. Ports A and B also each emit a one-cycle DMA trigger pulse when any pin that the pad configuration marks as a general-purpose input changes level in either direction. Interrupt vectoring, the DMA engine and the pad drivers live outside this block.

Top module: `gpio_irq_flags`

## Requirements
- R1: After synchronous reset, all flags, enables and control bits are 0, and `irq_a`, `irq_b`, `irq_c`, `dma_a` and `dma_b` are low.
- R2: A pin change is seen by the flag on the third rising clock edge after it is applied. Control register (address 4) bits 3, 4 and 5 select falling-edge detection for ports A, B and C respectively. A value of 0 selects rising-edge detection, and an edge of the other polarity sets no flag.
- R3: A qualifying edge sets the pin's flag even when no enable for that pin or port is set.
- R4: A write to a flag register (address 0 for A, 1 for B, 2 for C in bits 4..0) clears each flag bit written as 0 and leaves each bit written as 1 unchanged.
- R5: When a new edge and a clearing write hit the same flag bit on the same clock edge, the flag ends up set.
- R6: `irq_a` is high while port enable bit 0 is set and either (control bit 0 is set and a flag among pins 3..0 is set) or (control bit 1 is set and a flag among pins 7..4 is set).
- R7: `irq_b` is high while port enable bit 1 is set and some port-B flag is set whose bit in the per-pin enable register (address 3) is 1.
- R8: `irq_c` is high while port enable bit 2 is set, the shared control bit 2 is set, and any port-C flag is set.
- R9: With its bit in the port enable register (address 5: bit 0 A, bit 1 B, bit 2 C) cleared, a port's request stays low whatever its flags and pin enables are.
- R10: `dma_a` / `dma_b` pulse high for exactly one cycle, on the same cycle a flag would set, after either transition of a pin whose `gpio_in_a` / `gpio_in_b` bit is 1. Transitions on pins whose bit is 0 produce no pulse.
- R11: `bus_rdata` shows the addressed register in the same cycle. Unused upper bits read 0, the control register holds 6 bits, the port enable register holds 3 bits, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 8 | Asynchronous port A pin levels |
| pin_b | input | 8 | Asynchronous port B pin levels |
| pin_c | input | 5 | Asynchronous port C pin levels |
| gpio_in_a | input | 8 | 1 where a port A pin is configured as a general-purpose input |
| gpio_in_b | input | 8 | 1 where a port B pin is configured as a general-purpose input |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |
| irq_c | output | 1 | Port C interrupt request |
| dma_a | output | 1 | Port A DMA trigger pulse |
| dma_b | output | 1 | Port B DMA trigger pulse |

## Verification
A pin change applied in cycle c reaches the flags, the requests and the DMA pulses in cycle c+3, and the pulse is gone again in cycle c+4. A register write driven in cycle c shows in the readback and in the requests in cycle c+1, and reads are combinational in the cycle the address is driven. The bench's driver stamps every expected item with its due cycle from these latencies. The monitor compares the item only in that cycle, half a clock after the edge. The set-beats-clear case is arranged by issuing the write in cycle c+2 so that both land on edge c+3.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    localparam int PA_W        = 8;
    localparam int PB_W        = 8;
    localparam int PC_W        = 5;
    localparam int DW          = 8;
    localparam int AW          = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [AW-1:0] {
        RA_FLAG_A = 3'd0,
        RA_FLAG_B = 3'd1,
        RA_FLAG_C = 3'd2,
        RA_BEN    = 3'd3,
        RA_CTRL   = 3'd4,
        RA_PEN    = 3'd5
    } reg_addr_e;

    // bit0 a_lo_en, bit1 a_hi_en, bit2 c_en, bit3..5 falling select A/B/C
    typedef struct packed {
        logic fall_c;
        logic fall_b;
        logic fall_a;
        logic c_en;
        logic a_hi_en;
        logic a_lo_en;
    } ctrl_t;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } port_en_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PEN_W  = $bits(port_en_t);

    function automatic logic [PA_W-1:0] nibble_mask(input logic lo, input logic hi);
        return {{(PA_W - PA_W/2){hi}}, {(PA_W/2){lo}}};
    endfunction

    function automatic logic addr_hit(input logic wen, input logic [AW-1:0] addr,
                                      input reg_addr_e target);
        return wen && (addr == target);
    endfunction

endpackage

// File: rtl/gpf_edge_det.sv
module gpf_edge_det #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic         fall_sel_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] toggle_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;
    logic [W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= pin_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign cur = stg[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    assign hit_o    = fall_sel_i ? (~cur & prev_q) : (cur & ~prev_q);
    assign toggle_o = cur ^ prev_q;
endmodule

// File: rtl/gpf_flag_bank.sv
module gpf_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    always_ff @(posedge clk) begin
        if (rst) flag_o <= '0;
        else     flag_o <= (flag_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/gpf_regs.sv
module gpf_regs
    import gpf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wen_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [PA_W-1:0] flag_a_i,
    input  logic [PB_W-1:0] flag_b_i,
    input  logic [PC_W-1:0] flag_c_i,
    output logic [PB_W-1:0] ben_o,
    output ctrl_t           ctrl_o,
    output port_en_t        pen_o,
    output logic [DW-1:0]   rdata_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ben_o  <= '0;
            ctrl_o <= '0;
            pen_o  <= '0;
        end else begin
            if (addr_hit(wen_i, addr_i, RA_BEN))  ben_o  <= wdata_i[PB_W-1:0];
            if (addr_hit(wen_i, addr_i, RA_CTRL)) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            if (addr_hit(wen_i, addr_i, RA_PEN))  pen_o  <= port_en_t'(wdata_i[PEN_W-1:0]);
        end
    end

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            RA_FLAG_A: rdata_o[PA_W-1:0]   = flag_a_i;
            RA_FLAG_B: rdata_o[PB_W-1:0]   = flag_b_i;
            RA_FLAG_C: rdata_o[PC_W-1:0]   = flag_c_i;
            RA_BEN:    rdata_o[PB_W-1:0]   = ben_o;
            RA_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_o;
            RA_PEN:    rdata_o[PEN_W-1:0]  = pen_o;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags
    import gpf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PA_W-1:0] pin_a,
    input  logic [PB_W-1:0] pin_b,
    input  logic [PC_W-1:0] pin_c,
    input  logic [PA_W-1:0] gpio_in_a,
    input  logic [PB_W-1:0] gpio_in_b,
    input  logic            bus_wen,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_a,
    output logic            irq_b,
    output logic            irq_c,
    output logic            dma_a,
    output logic            dma_b
);
    logic [PA_W-1:0] hit_a, tog_a, clr_a, flag_a;
    logic [PB_W-1:0] hit_b, tog_b, clr_b, flag_b, ben;
    logic [PC_W-1:0] hit_c, tog_c_unused, clr_c, flag_c;
    ctrl_t           ctrl;
    port_en_t        pen;

    gpf_edge_det #(.W(PA_W), .STAGES(SYNC_STAGES)) u_edge_a (
        .clk(clk), .rst(rst), .pin_i(pin_a), .fall_sel_i(ctrl.fall_a),
        .hit_o(hit_a), .toggle_o(tog_a));
    gpf_edge_det #(.W(PB_W), .STAGES(SYNC_STAGES)) u_edge_b (
        .clk(clk), .rst(rst), .pin_i(pin_b), .fall_sel_i(ctrl.fall_b),
        .hit_o(hit_b), .toggle_o(tog_b));
    gpf_edge_det #(.W(PC_W), .STAGES(SYNC_STAGES)) u_edge_c (
        .clk(clk), .rst(rst), .pin_i(pin_c), .fall_sel_i(ctrl.fall_c),
        .hit_o(hit_c), .toggle_o(tog_c_unused));

    assign clr_a = addr_hit(bus_wen, bus_addr, RA_FLAG_A) ? ~bus_wdata[PA_W-1:0] : '0;
    assign clr_b = addr_hit(bus_wen, bus_addr, RA_FLAG_B) ? ~bus_wdata[PB_W-1:0] : '0;
    assign clr_c = addr_hit(bus_wen, bus_addr, RA_FLAG_C) ? ~bus_wdata[PC_W-1:0] : '0;

    gpf_flag_bank #(.W(PA_W)) u_flags_a (
        .clk(clk), .rst(rst), .set_i(hit_a), .clr_i(clr_a), .flag_o(flag_a));
    gpf_flag_bank #(.W(PB_W)) u_flags_b (
        .clk(clk), .rst(rst), .set_i(hit_b), .clr_i(clr_b), .flag_o(flag_b));
    gpf_flag_bank #(.W(PC_W)) u_flags_c (
        .clk(clk), .rst(rst), .set_i(hit_c), .clr_i(clr_c), .flag_o(flag_c));

    gpf_regs u_regs (
        .clk(clk), .rst(rst), .wen_i(bus_wen), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .flag_a_i(flag_a), .flag_b_i(flag_b), .flag_c_i(flag_c),
        .ben_o(ben), .ctrl_o(ctrl), .pen_o(pen), .rdata_o(bus_rdata));

    assign irq_a = pen.a && ((flag_a & nibble_mask(ctrl.a_lo_en, ctrl.a_hi_en)) != '0);
    assign irq_b = pen.b && ((flag_b & ben) != '0);
    assign irq_c = pen.c && ctrl.c_en && (flag_c != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_a <= 1'b0;
            dma_b <= 1'b0;
        end else begin
            dma_a <= (tog_a & gpio_in_a) != '0;
            dma_b <= (tog_b & gpio_in_b) != '0;
        end
    end
endmodule

// File: rtl/gpio_irq_flags_chk.sv
module gpio_irq_flags_chk
    import gpf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [PA_W-1:0] pin_a,
    input logic [PA_W-1:0] flag_a,
    input logic [PC_W-1:0] flag_c,
    input logic            bus_wen,
    input logic [AW-1:0]   bus_addr,
    input port_en_t        pen,
    input ctrl_t           ctrl,
    input logic            irq_a,
    input logic            irq_c,
    input logic            dma_a
);
    logic [2:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= '0;
        else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
    end
    assign warm = (warm_cnt >= 3'd5);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_a && !irq_c && !dma_a)); // R1

    AST_FLAG_NEEDS_PIN_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (warm && ((flag_a & ~$past(flag_a)) != '0)) |-> ($past(pin_a, 3) != $past(pin_a, 4))); // R2

    AST_FLAG_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (($past(flag_a) & ~flag_a) != '0) |-> ($past(bus_wen) && $past(bus_addr) == RA_FLAG_A)); // R4

    AST_IRQ_C_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_c |-> (ctrl.c_en && flag_c != '0)); // R8

    AST_IRQ_A_PORT_GATE: assert property (@(posedge clk) disable iff (rst)
        !pen.a |-> !irq_a); // R9

    AST_DMA_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (warm && dma_a) |-> ($past(pin_a, 3) != $past(pin_a, 4))); // R10
endmodule

bind gpio_irq_flags gpio_irq_flags_chk u_chk (.*);

// File: tb/gpio_irq_flags_test.sv
`timescale 1ns/1ps
module gpio_irq_flags_test;
    import gpf_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PA_W-1:0] pin_a = '0, gpio_in_a = '0;
    logic [PB_W-1:0] pin_b = '0, gpio_in_b = '0;
    logic [PC_W-1:0] pin_c = '0;
    logic            bus_wen = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            irq_a, irq_b, irq_c, dma_a, dma_b;

    gpio_irq_flags uut (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .gpio_in_a(gpio_in_a), .gpio_in_b(gpio_in_b), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c), .dma_a(dma_a), .dma_b(dma_b));

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    localparam int K_RD = 0, K_IRQ = 1, K_DMA = 2;
    typedef struct {
        int         due;
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_exp(input int kind, input logic [7:0] exp, input int dly, input string req);
        item_t it;
        it.due  = cyc + dly;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wen   = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
        bus_addr = a;
        push_exp(K_RD, e, 0, req);
        tick();
    endtask

    // monitor: compare every item in exactly its due cycle
    initial begin
        logic [7:0] act;
        forever begin
            @(negedge clk);
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    case (q[i].kind)
                        K_RD:    act = bus_rdata;
                        K_IRQ:   act = {5'b0, irq_c, irq_b, irq_a};
                        default: act = {6'b0, dma_b, dma_a};
                    endcase
                    total++;
                    if (act !== q[i].exp) begin
                        bad++;
                        $display("FAIL %s kind=%0d actual=%h expected=%h cycle=%0d",
                                 q[i].req, q[i].kind, act, q[i].exp, cyc);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1 / R11: reset state
        push_exp(K_IRQ, 8'h00, 0, "R1 irq");
        push_exp(K_DMA, 8'h00, 0, "R1 dma");
        for (int a = 0; a < 8; a++) rd(AW'(a), 8'h00, "R1 R11 reset readback");

        // R2 R3 R10: rising edges on A, nothing enabled
        gpio_in_a = 8'hFF;
        gpio_in_b = 8'h0F;
        pin_a = 8'h05;
        push_exp(K_DMA, 8'h01, 3, "R10 dma_a pulse");
        push_exp(K_DMA, 8'h00, 4, "R10 dma_a one cycle");
        push_exp(K_IRQ, 8'h00, 3, "R3 no irq without enables");
        repeat (3) tick();
        rd(RA_FLAG_A, 8'h05, "R2 R3 flag A set");

        // R10: port B transitions on non-GPIO pins give no pulse
        pin_b = 8'hF0;
        push_exp(K_DMA, 8'h00, 3, "R10 masked pins no pulse");
        push_exp(K_DMA, 8'h00, 4, "R10 masked pins no pulse");
        repeat (3) tick();
        rd(RA_FLAG_B, 8'hF0, "R2 flag B set");
        pin_b = 8'hF1;
        push_exp(K_DMA, 8'h02, 3, "R10 dma_b pulse");
        repeat (3) tick();
        rd(RA_FLAG_B, 8'hF1, "R2 flag B bit0");

        // R4: write-zero clear, write-one keep
        wr(RA_FLAG_A, 8'hFE);
        rd(RA_FLAG_A, 8'h04, "R4 clear bit0");
        wr(RA_FLAG_A, 8'hFF);
        rd(RA_FLAG_A, 8'h04, "R4 write one keeps");
        wr(RA_FLAG_A, 8'h00);
        rd(RA_FLAG_A, 8'h00, "R4 clear all");

        // R2: falling-edge select on port A
        wr(RA_CTRL, 8'h08);
        pin_a = 8'h01;
        push_exp(K_DMA, 8'h01, 3, "R10 falling transition pulse");
        repeat (3) tick();
        rd(RA_FLAG_A, 8'h04, "R2 falling edge sets");
        pin_a = 8'h81;
        push_exp(K_DMA, 8'h01, 3, "R10 rising transition pulse");
        repeat (3) tick();
        rd(RA_FLAG_A, 8'h04, "R2 rising ignored in falling mode");

        // R6 / R9: nibble enables on port A
        wr(RA_PEN, 8'h01);
        push_exp(K_IRQ, 8'h00, 0, "R6 nibble enables off");
        tick();
        wr(RA_CTRL, 8'h09);
        push_exp(K_IRQ, 8'h01, 0, "R6 low nibble enabled");
        tick();
        wr(RA_CTRL, 8'h0A);
        push_exp(K_IRQ, 8'h00, 0, "R6 only high nibble enabled");
        tick();
        wr(RA_CTRL, 8'h09);
        wr(RA_PEN, 8'h00);
        push_exp(K_IRQ, 8'h00, 0, "R9 port enable off");
        tick();

        // R7: per-pin enables on port B (flags F1)
        wr(RA_BEN, 8'h0E);
        wr(RA_PEN, 8'h02);
        push_exp(K_IRQ, 8'h00, 0, "R7 no enabled flag");
        tick();
        wr(RA_BEN, 8'h10);
        push_exp(K_IRQ, 8'h02, 0, "R7 enabled flag");
        tick();

        // R8: shared enable on port C
        wr(RA_PEN, 8'h04);
        wr(RA_CTRL, 8'h0D);
        pin_c = 5'h11;
        push_exp(K_IRQ, 8'h04, 3, "R8 irq_c raised");
        push_exp(K_DMA, 8'h00, 3, "R10 port C no dma");
        repeat (3) tick();
        rd(RA_FLAG_C, 8'h11, "R8 flag C");
        wr(RA_FLAG_C, 8'hFF);
        rd(RA_FLAG_C, 8'h11, "R4 port C write one keeps");
        wr(RA_CTRL, 8'h09);
        push_exp(K_IRQ, 8'h00, 0, "R8 common enable off");
        tick();
        wr(RA_CTRL, 8'h0D);
        wr(RA_FLAG_C, 8'hEE);
        push_exp(K_IRQ, 8'h00, 0, "R8 flags cleared");
        rd(RA_FLAG_C, 8'h00, "R4 port C cleared");

        // R5: set and clear on the same edge
        pin_c = 5'h13;
        tick();
        tick();
        wr(RA_FLAG_C, 8'hFD);
        push_exp(K_IRQ, 8'h04, 0, "R5 irq_c after set wins");
        rd(RA_FLAG_C, 8'h02, "R5 set beats clear");

        // R11: register widths and empty addresses
        wr(RA_CTRL, 8'hFF);
        rd(RA_CTRL, 8'h3F, "R11 control width");
        rd(3'd6, 8'h00, "R11 empty address 6");
        rd(3'd7, 8'h00, "R11 empty address 7");
        wr(RA_PEN, 8'hFF);
        rd(RA_PEN, 8'h07, "R11 port enable width");
        rd(RA_BEN, 8'h10, "R11 pin enable readback");

        repeat (6) tick();
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule